// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block turns the control fields of a clock generator into one registered operating mode. Its inputs are a two-bit clock-source select, an internal-reference select, a PLL select, a low-power request, a debug-active flag and the PLL lock indication. From the registered mode it drives the output clock mux select, the PLL enable, the FLL enable and the debug-clock source select. It also reports the mode as a three-bit code, together with a status that stays high while the PLL has not yet settled in the PLL bypassed external mode.

The mode is a state machine. Its state register loads the decoded mode on every clock edge. The states are FEI (FLL engaged internal, the reset state), FBI (FLL bypassed internal), PBE (PLL bypassed external), BLPI (bypassed low-power internal), BLPE (bypassed low-power external), PBI (PLL bypassed internal), FBE (FLL bypassed external) and BAD (unsupported combination). Any state can move to any other state in one edge. The transition taken is the decode of the inputs sampled at that edge. When debug is active, a low-power request is ignored, so the machine goes to PBI/PBE or FBI/FBE in place of BLPI/BLPE. The oscillators, the PLL, the FLL and glitch-free switching are outside this block.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: An asynchronous active-low reset puts the block in FEI: mode_code 0, clk_mux_sel 0, pll_en 0, fll_en 1, dbg_clk_sel 1, lock_wait 0.
- R2: src_sel=2'b10, int_ref_sel=0, pll_sel=1, low_pwr=0 selects PBE: mode_code 2, clk_mux_sel 2 (external reference), pll_en 1.
- R3: In PBE and in PBI with debug active, fll_en is 1 and dbg_clk_sel is 2 (open-loop FLL divided by two). Without debug in those modes, fll_en is 0 and dbg_clk_sel is 0 (no debug clock).
- R4: src_sel=2'b01, int_ref_sel=1, low_pwr=1 with debug inactive selects BLPI: mode_code 3, clk_mux_sel 1 (internal reference), pll_en 0, fll_en 0, dbg_clk_sel 0. pll_sel has no effect in this case.
- R5: src_sel=2'b10, int_ref_sel=0, low_pwr=1 with debug inactive selects BLPE: mode_code 4, clk_mux_sel 2, pll_en 0, fll_en 0, dbg_clk_sel 0. pll_sel has no effect in this case.
- R6: With debug active, low_pwr is ignored. On the internal path, pll_sel=1 gives PBI (code 5) and pll_sel=0 gives FBI (code 1). On the external path, pll_sel=1 gives PBE (code 2) and pll_sel=0 gives FBE (code 6).
- R7: FBI drives clk_mux_sel 1, pll_en 0, fll_en 1, dbg_clk_sel 1. PBI drives clk_mux_sel 1, pll_en 1. FBE drives clk_mux_sel 2, pll_en 0, fll_en 1, dbg_clk_sel 1.
- R8: src_sel=2'b00, int_ref_sel=1, pll_sel=0 selects FEI (code 0) whatever low_pwr and debug are.
- R9: Every other combination gives mode_code 7 and drives the FEI output settings.
- R10: Every output follows the inputs sampled at the previous rising edge. A change of input between edges does not reach the outputs.
- R11: lock_wait is high only in PBE. It goes low once pll_lock has been sampled high at LOCK_CYC (default 2) consecutive edges while the block was in PBE. Any edge in PBE with pll_lock low restarts the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Clock-source select |
| int_ref_sel | input | 1 | 1 = internal reference, 0 = external |
| pll_sel | input | 1 | 1 = PLL path, 0 = FLL path |
| low_pwr | input | 1 | Low-power bypass request |
| dbg_active | input | 1 | Debug interface active |
| pll_lock | input | 1 | Lock indication from the PLL |
| clk_mux_sel | output | 2 | 0 = loop output, 1 = internal ref, 2 = external ref |
| pll_en | output | 1 | PLL enable |
| fll_en | output | 1 | FLL enable |
| dbg_clk_sel | output | 2 | 0 = none, 1 = FLL, 2 = open-loop FLL / 2 |
| mode_code | output | 3 | Current mode code |
| lock_wait | output | 1 | PLL settling in PBE |

## Verification
A wrong state register shows at once: the mode code and the whole output bundle mismatch on the negative edge after the rising edge that loaded the state. A debug flag captured at the wrong time shows only in PBE and PBI, as fll_en and dbg_clk_sel one cycle off. A lock counter that is not cleared correctly shows on lock_wait in the first two cycles after PBE is entered, or in the cycle after lock drops.

// File: rtl/cgm_pkg.sv
package cgm_pkg;
    typedef enum logic [2:0] {
        MD_FEI  = 3'd0,
        MD_FBI  = 3'd1,
        MD_PBE  = 3'd2,
        MD_BLPI = 3'd3,
        MD_BLPE = 3'd4,
        MD_PBI  = 3'd5,
        MD_FBE  = 3'd6,
        MD_BAD  = 3'd7
    } cgm_mode_e;

    localparam logic [1:0] MUX_LOOP = 2'd0;
    localparam logic [1:0] MUX_IREF = 2'd1;
    localparam logic [1:0] MUX_EREF = 2'd2;

    localparam logic [1:0] DBG_NONE = 2'd0;
    localparam logic [1:0] DBG_FLL  = 2'd1;
    localparam logic [1:0] DBG_HALF = 2'd2;

    localparam logic [1:0] SRC_LOOP = 2'b00;
    localparam logic [1:0] SRC_IREF = 2'b01;
    localparam logic [1:0] SRC_EREF = 2'b10;

    typedef struct packed {
        logic [1:0] mux_sel;
        logic       pll_en;
        logic       fll_en;
        logic [1:0] dbg_sel;
    } cgm_ctl_t;
endpackage

// File: rtl/cgm_mode_decode.sv
module cgm_mode_decode
    import cgm_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       int_ref_sel,
    input  logic       pll_sel,
    input  logic       low_pwr,
    input  logic       dbg_active,
    output cgm_mode_e  next_mode
);
    logic lp_eff;

    always_comb begin
        lp_eff    = low_pwr & ~dbg_active;
        next_mode = MD_BAD;
        unique case (src_sel)
            SRC_LOOP: begin
                if (int_ref_sel && !pll_sel)
                    next_mode = MD_FEI;
            end
            SRC_IREF: begin
                if (int_ref_sel) begin
                    if (lp_eff)
                        next_mode = MD_BLPI;
                    else if (pll_sel)
                        next_mode = MD_PBI;
                    else
                        next_mode = MD_FBI;
                end
            end
            SRC_EREF: begin
                if (!int_ref_sel) begin
                    if (lp_eff)
                        next_mode = MD_BLPE;
                    else if (pll_sel)
                        next_mode = MD_PBE;
                    else
                        next_mode = MD_FBE;
                end
            end
            default: next_mode = MD_BAD;
        endcase
    end
endmodule

// File: rtl/cgm_out_map.sv
module cgm_out_map
    import cgm_pkg::*;
(
    input  cgm_mode_e mode,
    input  logic      dbg_q,
    output cgm_ctl_t  ctl
);
    always_comb begin
        ctl = '{mux_sel: MUX_LOOP, pll_en: 1'b0, fll_en: 1'b1, dbg_sel: DBG_FLL};
        unique case (mode)
            MD_FEI, MD_BAD: ;
            MD_FBI: ctl.mux_sel = MUX_IREF;
            MD_FBE: ctl.mux_sel = MUX_EREF;
            MD_PBE, MD_PBI: begin
                ctl.mux_sel = (mode == MD_PBE) ? MUX_EREF : MUX_IREF;
                ctl.pll_en  = 1'b1;
                ctl.fll_en  = dbg_q;
                ctl.dbg_sel = dbg_q ? DBG_HALF : DBG_NONE;
            end
            MD_BLPI, MD_BLPE: begin
                ctl.mux_sel = (mode == MD_BLPE) ? MUX_EREF : MUX_IREF;
                ctl.fll_en  = 1'b0;
                ctl.dbg_sel = DBG_NONE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cgm_lock_mon.sv
module cgm_lock_mon #(
    parameter int LOCK_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_pbe,
    input  logic pll_lock,
    output logic lock_wait
);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LOCK_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (in_pbe && pll_lock) begin
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end else
            cnt_q <= '0;
    end

    assign lock_wait = in_pbe && (cnt_q != CNT_MAX);

    // R11: a low lock sample in PBE keeps or restarts the wait
    p_wait_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pbe && !pll_lock) |=> (!in_pbe || lock_wait));

    // R11: the wait status never shows outside PBE
    p_wait_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wait |-> in_pbe);
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import cgm_pkg::*;
#(
    parameter int LOCK_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       int_ref_sel,
    input  logic       pll_sel,
    input  logic       low_pwr,
    input  logic       dbg_active,
    input  logic       pll_lock,
    output logic [1:0] clk_mux_sel,
    output logic       pll_en,
    output logic       fll_en,
    output logic [1:0] dbg_clk_sel,
    output logic [2:0] mode_code,
    output logic       lock_wait
);
    cgm_mode_e mode_q;
    cgm_mode_e mode_d;
    logic      dbg_q;
    cgm_ctl_t  ctl;

    cgm_mode_decode u_dec (
        .src_sel     (src_sel),
        .int_ref_sel (int_ref_sel),
        .pll_sel     (pll_sel),
        .low_pwr     (low_pwr),
        .dbg_active  (dbg_active),
        .next_mode   (mode_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_FEI;
            dbg_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            dbg_q  <= dbg_active;
        end
    end

    cgm_out_map u_map (
        .mode  (mode_q),
        .dbg_q (dbg_q),
        .ctl   (ctl)
    );

    cgm_lock_mon #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_pbe    (mode_q == MD_PBE),
        .pll_lock  (pll_lock),
        .lock_wait (lock_wait)
    );

    assign clk_mux_sel = ctl.mux_sel;
    assign pll_en      = ctl.pll_en;
    assign fll_en      = ctl.fll_en;
    assign dbg_clk_sel = ctl.dbg_sel;
    assign mode_code   = mode_q;

    // R2: PBE routes the external reference and runs the PLL
    p_pbe_routes_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd2) |-> (pll_en && clk_mux_sel == 2'd2));

    // R3: the halved debug clock needs a running FLL
    p_half_needs_fll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_clk_sel == 2'd2) |-> fll_en);

    // R4/R5: low-power bypass modes stop both loops
    p_lp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd3 || mode_code == 3'd4) |-> (!pll_en && !fll_en && dbg_clk_sel == 2'd0));

    // R6: an active debug flag keeps the next mode out of low power
    p_dbg_leaves_lp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active |=> (mode_code != 3'd3 && mode_code != 3'd4));

    // R9: unsupported code drives the default settings
    p_bad_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd7) |-> (clk_mux_sel == 2'd0 && !pll_en && fll_en && dbg_clk_sel == 2'd1));
endmodule

// File: tb/sim_clkgen_mode_ctrl.sv
module sim_clkgen_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       int_ref_sel = 1'b1;
    logic       pll_sel = 1'b0;
    logic       low_pwr = 1'b0;
    logic       dbg_active = 1'b0;
    logic       pll_lock = 1'b0;
    logic [1:0] clk_mux_sel;
    logic       pll_en;
    logic       fll_en;
    logic [1:0] dbg_clk_sel;
    logic [2:0] mode_code;
    logic       lock_wait;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] m_mode = 3'd0;
    logic       m_dbg = 1'b0;
    int         m_cnt = 0;

    always #4 clk = ~clk;

    clkgen_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .int_ref_sel(int_ref_sel),
        .pll_sel(pll_sel), .low_pwr(low_pwr), .dbg_active(dbg_active), .pll_lock(pll_lock),
        .clk_mux_sel(clk_mux_sel), .pll_en(pll_en), .fll_en(fll_en),
        .dbg_clk_sel(dbg_clk_sel), .mode_code(mode_code), .lock_wait(lock_wait)
    );

    function automatic logic [2:0] exp_mode(logic [1:0] s, logic ir, logic ps, logic lp, logic dbg);
        logic lpe = lp & ~dbg;
        if (s == 2'b00 && ir && !ps) return 3'd0;
        if (s == 2'b01 && ir)  return lpe ? 3'd3 : (ps ? 3'd5 : 3'd1);
        if (s == 2'b10 && !ir) return lpe ? 3'd4 : (ps ? 3'd2 : 3'd6);
        return 3'd7;
    endfunction

    // {mode(3), mux(2), pll, fll, dbgsel(2), wait}
    function automatic logic [9:0] exp_out(logic [2:0] md, logic dbg, int cnt);
        logic [1:0] mux = 2'd0; logic p = 1'b0; logic f = 1'b1; logic [1:0] d = 2'd1;
        case (md)
            3'd1: mux = 2'd1;
            3'd6: mux = 2'd2;
            3'd2, 3'd5: begin
                mux = (md == 3'd2) ? 2'd2 : 2'd1; p = 1'b1; f = dbg; d = dbg ? 2'd2 : 2'd0;
            end
            3'd3, 3'd4: begin
                mux = (md == 3'd4) ? 2'd2 : 2'd1; f = 1'b0; d = 2'd0;
            end
            default: ;
        endcase
        return {md, mux, p, f, d, (md == 3'd2) && (cnt < 2)};
    endfunction

    function automatic string tag_of(logic [2:0] md);
        case (md)
            3'd0: return "R8";
            3'd2: return "R2";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd7: return "R9";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [9:0] act_out();
        return {mode_code, clk_mux_sel, pll_en, fll_en, dbg_clk_sel, lock_wait};
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at negedge, model the rising edge, compare at the next negedge
    task automatic step(logic [1:0] s, logic ir, logic ps, logic lp, logic dbg, logic lk, string tag);
        src_sel = s; int_ref_sel = ir; pll_sel = ps; low_pwr = lp; dbg_active = dbg; pll_lock = lk;
        @(posedge clk);
        m_cnt  = (m_mode == 3'd2 && lk) ? ((m_cnt < 2) ? m_cnt + 1 : 2) : 0;
        m_mode = exp_mode(s, ir, ps, lp, dbg);
        m_dbg  = dbg;
        @(negedge clk);
        check(tag, act_out(), exp_out(m_mode, m_dbg, m_cnt));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #3;
        // R1: reset state
        check("R1", act_out(), 10'b000_00_0_1_01_0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R1", act_out(), 10'b000_00_0_1_01_0);

        // R2 and R3: PBE without and with debug
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
        check("R3", {fll_en, dbg_clk_sel}, {7'd0, 1'b1, 2'd2});
        // R4: BLPI, pll_sel both ways
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        step(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
        // R5: BLPE, pll_sel both ways
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        step(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        // R6: debug overrides low power
        step(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", {7'd0, mode_code}, 10'd5);
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", {7'd0, mode_code}, 10'd1);
        step(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", {7'd0, mode_code}, 10'd2);
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", {7'd0, mode_code}, 10'd6);
        // R7: FBI, PBI without debug, FBE
        step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        step(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R8: FEI with low power and debug asserted
        step(2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        // R9: unsupported combinations
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        // R10: input change between edges does not reach outputs
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        src_sel = 2'b10; int_ref_sel = 1'b0; pll_sel = 1'b1; low_pwr = 1'b0;
        #2;
        check("R10", act_out(), exp_out(3'd3, 1'b0, 0));
        // R11: lock wait sequence
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        check("R11", {9'd0, lock_wait}, 10'd1);
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        check("R11", {9'd0, lock_wait}, 10'd1);
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        check("R11", {9'd0, lock_wait}, 10'd0);
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        check("R11", {9'd0, lock_wait}, 10'd1);
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
        check("R11", {9'd0, lock_wait}, 10'd0);

        // random mix, biased toward the external PLL path to exercise locking
        for (int i = 0; i < 600; i++) begin
            logic [6:0] r = 7'($urandom());
            logic [1:0] s = r[1:0];
            logic ir = r[2];
            logic ps = r[3];
            if ($urandom_range(0, 3) == 0) begin s = 2'b10; ir = 1'b0; ps = 1'b1; end
            step(s, ir, ps, r[4], ($urandom_range(0, 3) == 0), r[6] | r[5],
                 tag_of(exp_mode(s, ir, ps, r[4], 1'b0)));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule